// File: doc/BRIEF.md
# Serial Link Configuration Bank with Lane Steering

This block holds the configuration of a two-converter serial link transmitter. For each of two links it keeps eight link parameters (converters per link, sample container width, control bits per frame, frames per multiframe, samples per converter per frame, octets per frame, lanes per link, high-density flag) and one opaque link control byte. It also keeps a sync-source selection and a lane-assignment code. All of these registers are reached through a simple single-cycle write port and a combinational read port.

A 3-bit quick-setup field sits at its own address. Writing one of the supported codes to it rewrites a whole group of registers in the same write cycle, so the three common link arrangements need only one write to set up. The field clears itself and always reads 0. The registers it rewrites can still be read and overwritten one by one afterwards.

The lane-assignment code drives a steering datapath. That datapath routes four 16-bit source streams (lane 0 and lane 1 of link A, lane 0 and lane 1 of link B) onto two physical output lanes, with one register stage.

Top module: `linkCfgBank`

## Requirements
- R1: The quick-setup field at address 0x00 always reads 0x00. Writing code 000 to it leaves every register unchanged.
- R2: Quick code 001 sets both links to M=1, N'=16, CF=0, K=16, S=1, F=2, L=1, HD=0. It clears the sync select and sets the lane code to 0000. The control bytes are left as they were.
- R3: Quick code 010 sets both links to M=2, N'=16, CF=0, K=16, S=1, F=2, L=2, HD=0. It sets the sync select to 1 (both links take the A sync input) and the lane code to 0010. It sets the link A control byte to 0x14 and the link B control byte to 0x01.
- R4: Quick code 011 sets both links to M=2, N'=16, CF=0, K=8, S=1, F=4, L=1, HD=0. It sets the sync select to 1 and the lane code to 0000. The control bytes are left as they were.
- R5: Quick codes 100 to 111 change no register.
- R6: Preset values can be read back in the cycle after the write, and a later write to any of those registers replaces the preset value.
- R7: Lane code 0000 puts link A lane 0 on physical lane A and link B lane 0 on physical lane B. Lane code 0001 swaps the two.
- R8: Lane codes 0010 and 0011 put link A lanes 0/1 on physical lanes A/B and B/A respectively. Codes 0100 and 0101 do the same with link B's lanes.
- R9: A write of lane code 0110 to 1111 is ignored, and the register and the routing keep their previous value. After reset the lane register reads 0xF and both physical lanes are disabled. A disabled lane outputs data 0 with valid low.
- R10: An enabled physical lane shows the selected source's data and valid one clock after they are presented.
- R11: Address map: 0x01 holds the lane code in bits 3:0, 0x02 holds the sync select in bit 0, 0x10+i holds link A field i and 0x20+i holds link B field i. The fields are i = 0 M, 1 N', 2 CF, 3 K, 4 S, 5 F, 6 L, 7 HD, 8 control. The cfg outputs carry field i in bits 8i+7:8i. Addresses outside this map read 0 and ignore writes. After reset all fields and the sync select are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| addr | input | 6 | Register address for write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| linkACfg | output | 72 | Link A fields, field i in bits 8i+7:8i |
| linkBCfg | output | 72 | Link B fields, same layout |
| syncFromA | output | 1 | 1: both links take the A sync input |
| srcAData0 | input | 16 | Link A lane 0 stream |
| srcAData1 | input | 16 | Link A lane 1 stream |
| srcBData0 | input | 16 | Link B lane 0 stream |
| srcBData1 | input | 16 | Link B lane 1 stream |
| srcValid | input | 4 | Valid flags: bit 0 A0, 1 A1, 2 B0, 3 B1 |
| physAData | output | 16 | Physical lane A data |
| physAValid | output | 1 | Physical lane A valid |
| physBData | output | 16 | Physical lane B data |
| physBValid | output | 1 | Physical lane B valid |

## Verification
The properties assume wrEn, addr and wrData are defined in every cycle once reset is released, and at most one write per clock. They also assume each address outside the map is simply ignored rather than treated as an error. The stimulus changes inputs only on the falling clock edge. It never overlaps two writes, and it holds all source streams steady across each routing check, so every output checked comes from exactly one write or one source value.

// File: rtl/linkCfgPkg.sv
package linkCfgPkg;
  localparam int DATA_W      = 8;
  localparam int LANE_W      = 16;
  localparam int NUM_LINKS   = 2;
  localparam int NUM_FIELDS  = 9;
  localparam int CFG_W       = NUM_FIELDS * DATA_W;
  localparam int NUM_SRC     = 4;
  localparam int NUM_PHYS    = 2;
  localparam int QCFG_W      = 3;
  localparam int LANE_CODE_W = 4;

  localparam int FLD_M   = 0;
  localparam int FLD_NP  = 1;
  localparam int FLD_CF  = 2;
  localparam int FLD_K   = 3;
  localparam int FLD_S   = 4;
  localparam int FLD_F   = 5;
  localparam int FLD_L   = 6;
  localparam int FLD_HD  = 7;
  localparam int FLD_CTL = 8;

  localparam logic [LANE_CODE_W-1:0] LANE_CODE_MAX  = 4'd5;
  localparam logic [LANE_CODE_W-1:0] LANE_UNASSIGNED = 4'hF;

  typedef enum logic [1:0] {SRC_A0 = 2'd0, SRC_A1 = 2'd1, SRC_B0 = 2'd2, SRC_B1 = 2'd3} laneSrc_e;

  typedef struct packed {
    logic [NUM_PHYS-1:0]   en;
    laneSrc_e [NUM_PHYS-1:0] sel;
  } laneRoute_t;
endpackage

// File: rtl/linkCfgCtrl.sv
module linkCfgCtrl
  import linkCfgPkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int QCFG_ADDR  = 0,
  parameter int LANE_ADDR  = 1,
  parameter int SYNC_ADDR  = 2,
  parameter int LINKA_BASE = 16,
  parameter int LINKB_BASE = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              wrEn,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wrData,
  output logic [DATA_W-1:0]                 rdData,
  output logic [NUM_LINKS-1:0][CFG_W-1:0]   linkCfg,
  output logic                              syncFromA,
  output logic [LANE_CODE_W-1:0]            laneCode,
  output laneRoute_t                        route
);
  logic presetHit, presetCtl, presetSync;
  logic [LANE_CODE_W-1:0] presetLane;
  logic [DATA_W-1:0] presetFld [NUM_FIELDS];
  logic [NUM_LINKS-1:0][DATA_W-1:0] linkRd;
  logic [LANE_CODE_W-1:0] laneQ;
  logic syncQ;
  logic qcfgWr;

  assign qcfgWr = wrEn && (addr == ADDR_W'(QCFG_ADDR));

  always_comb begin
    presetHit  = 1'b0;
    presetCtl  = 1'b0;
    presetSync = 1'b0;
    presetLane = '0;
    for (int f = 0; f < NUM_FIELDS; f++) presetFld[f] = '0;
    presetFld[FLD_NP] = 8'd16;
    presetFld[FLD_S]  = 8'd1;
    case (wrData[QCFG_W-1:0])
      3'b001: begin
        presetHit = 1'b1;
        presetFld[FLD_M] = 8'd1; presetFld[FLD_K] = 8'd16;
        presetFld[FLD_F] = 8'd2; presetFld[FLD_L] = 8'd1;
      end
      3'b010: begin
        presetHit = 1'b1; presetCtl = 1'b1; presetSync = 1'b1; presetLane = 4'd2;
        presetFld[FLD_M] = 8'd2; presetFld[FLD_K] = 8'd16;
        presetFld[FLD_F] = 8'd2; presetFld[FLD_L] = 8'd2;
      end
      3'b011: begin
        presetHit = 1'b1; presetSync = 1'b1;
        presetFld[FLD_M] = 8'd2; presetFld[FLD_K] = 8'd8;
        presetFld[FLD_F] = 8'd4; presetFld[FLD_L] = 8'd1;
      end
      default: presetHit = 1'b0;
    endcase
    if (!qcfgWr) presetHit = 1'b0;
  end

  for (genvar l = 0; l < NUM_LINKS; l++) begin : gLink
    localparam int BASE = (l == 0) ? LINKA_BASE : LINKB_BASE;
    localparam logic [DATA_W-1:0] CTL_PRESET = (l == 0) ? 8'h14 : 8'h01;
    logic [DATA_W-1:0] fldQ [NUM_FIELDS];
    logic [DATA_W-1:0] rdLocal;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int f = 0; f < NUM_FIELDS; f++) fldQ[f] <= '0;
      end else begin
        for (int f = 0; f < NUM_FIELDS; f++) begin
          if (presetHit) begin
            if (f == FLD_CTL) begin
              if (presetCtl) fldQ[f] <= CTL_PRESET;
            end else begin
              fldQ[f] <= presetFld[f];
            end
          end else if (wrEn && (addr == ADDR_W'(BASE + f))) begin
            fldQ[f] <= wrData;
          end
        end
      end
    end

    always_comb begin
      rdLocal = '0;
      for (int f = 0; f < NUM_FIELDS; f++)
        if (addr == ADDR_W'(BASE + f)) rdLocal = fldQ[f];
    end
    assign linkRd[l] = rdLocal;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : gOut
      assign linkCfg[l][f*DATA_W +: DATA_W] = fldQ[f];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      laneQ <= LANE_UNASSIGNED;
      syncQ <= 1'b0;
    end else if (presetHit) begin
      laneQ <= presetLane;
      syncQ <= presetSync;
    end else if (wrEn && addr == ADDR_W'(LANE_ADDR)) begin
      if (wrData[LANE_CODE_W-1:0] <= LANE_CODE_MAX) laneQ <= wrData[LANE_CODE_W-1:0];
    end else if (wrEn && addr == ADDR_W'(SYNC_ADDR)) begin
      syncQ <= wrData[0];
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(LANE_ADDR)) rdData = DATA_W'(laneQ);
    else if (addr == ADDR_W'(SYNC_ADDR)) rdData = DATA_W'(syncQ);
    else for (int l = 0; l < NUM_LINKS; l++) rdData = rdData | linkRd[l];
  end

  always_comb begin
    route.en     = '0;
    route.sel[0] = SRC_A0;
    route.sel[1] = SRC_A0;
    case (laneQ)
      4'd0: begin route.en = 2'b11; route.sel[0] = SRC_A0; route.sel[1] = SRC_B0; end
      4'd1: begin route.en = 2'b11; route.sel[0] = SRC_B0; route.sel[1] = SRC_A0; end
      4'd2: begin route.en = 2'b11; route.sel[0] = SRC_A0; route.sel[1] = SRC_A1; end
      4'd3: begin route.en = 2'b11; route.sel[0] = SRC_A1; route.sel[1] = SRC_A0; end
      4'd4: begin route.en = 2'b11; route.sel[0] = SRC_B0; route.sel[1] = SRC_B1; end
      4'd5: begin route.en = 2'b11; route.sel[0] = SRC_B1; route.sel[1] = SRC_B0; end
      default: route.en = '0;
    endcase
  end

  assign syncFromA = syncQ;
  assign laneCode  = laneQ;
endmodule

// File: rtl/linkLaneSteer.sv
module linkLaneSteer
  import linkCfgPkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  laneRoute_t                       route,
  input  logic [NUM_SRC-1:0][LANE_W-1:0]   srcData,
  input  logic [NUM_SRC-1:0]               srcValid,
  output logic [NUM_PHYS-1:0][LANE_W-1:0]  physData,
  output logic [NUM_PHYS-1:0]              physValid
);
  for (genvar p = 0; p < NUM_PHYS; p++) begin : gPhys
    logic [LANE_W-1:0] dataQ;
    logic validQ;
    always_ff @(posedge clk) begin
      if (!rstN || !route.en[p]) begin
        dataQ  <= '0;
        validQ <= 1'b0;
      end else begin
        dataQ  <= srcData[route.sel[p]];
        validQ <= srcValid[route.sel[p]];
      end
    end
    assign physData[p]  = dataQ;
    assign physValid[p] = validQ;
  end
endmodule

// File: rtl/linkCfgBank.sv
module linkCfgBank
  import linkCfgPkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int QCFG_ADDR  = 0,
  parameter int LANE_ADDR  = 1,
  parameter int SYNC_ADDR  = 2,
  parameter int LINKA_BASE = 16,
  parameter int LINKB_BASE = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [71:0]       linkACfg,
  output logic [71:0]       linkBCfg,
  output logic              syncFromA,
  input  logic [15:0]       srcAData0,
  input  logic [15:0]       srcAData1,
  input  logic [15:0]       srcBData0,
  input  logic [15:0]       srcBData1,
  input  logic [3:0]        srcValid,
  output logic [15:0]       physAData,
  output logic              physAValid,
  output logic [15:0]       physBData,
  output logic              physBValid
);
  logic [NUM_LINKS-1:0][CFG_W-1:0]  linkCfg;
  logic [LANE_CODE_W-1:0]           laneCode;
  laneRoute_t                       route;
  logic [NUM_SRC-1:0][LANE_W-1:0]   srcData;
  logic [NUM_PHYS-1:0][LANE_W-1:0]  physData;
  logic [NUM_PHYS-1:0]              physValid;

  assign srcData = {srcBData1, srcBData0, srcAData1, srcAData0};

  linkCfgCtrl #(
    .ADDR_W(ADDR_W), .QCFG_ADDR(QCFG_ADDR), .LANE_ADDR(LANE_ADDR),
    .SYNC_ADDR(SYNC_ADDR), .LINKA_BASE(LINKA_BASE), .LINKB_BASE(LINKB_BASE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .linkCfg(linkCfg), .syncFromA(syncFromA),
    .laneCode(laneCode), .route(route)
  );

  linkLaneSteer uSteer (
    .clk(clk), .rstN(rstN), .route(route), .srcData(srcData),
    .srcValid(srcValid), .physData(physData), .physValid(physValid)
  );

  assign linkACfg   = linkCfg[0];
  assign linkBCfg   = linkCfg[1];
  assign physAData  = physData[0];
  assign physAValid = physValid[0];
  assign physBData  = physData[1];
  assign physBValid = physValid[1];
endmodule

// File: rtl/linkCfgBankChk.sv
module linkCfgBankChk #(
  parameter int ADDR_W    = 6,
  parameter int QCFG_ADDR = 0,
  parameter int LANE_ADDR = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic [71:0]       linkACfg,
  input logic [71:0]       linkBCfg,
  input logic              syncFromA,
  input logic [3:0]        laneCode,
  input logic [15:0]       physAData,
  input logic              physAValid,
  input logic [15:0]       physBData,
  input logic              physBValid
);
  logic qWr;
  assign qWr = wrEn && (addr == ADDR_W'(QCFG_ADDR));

  AST_QCFG_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(QCFG_ADDR)) |-> (rdData == 8'h00)); // R1

  AST_PRESET_TWO_LINKS: assert property (@(posedge clk) disable iff (!rstN)
    (qWr && wrData[2:0] == 3'b001) |=> (linkACfg[7:0] == 8'd1 && linkBCfg[31:24] == 8'd16
      && !syncFromA && laneCode == 4'd0)); // R2

  AST_PRESET_ONE_LINK_TWO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    (qWr && wrData[2:0] == 3'b010) |=> (linkACfg[55:48] == 8'd2 && linkBCfg[55:48] == 8'd2
      && linkACfg[71:64] == 8'h14 && linkBCfg[71:64] == 8'h01 && syncFromA && laneCode == 4'd2)); // R3

  AST_RESERVED_QCFG_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (qWr && wrData[2]) |=> ($stable(linkACfg) && $stable(linkBCfg)
      && $stable(syncFromA) && $stable(laneCode))); // R5

  AST_RESERVED_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(LANE_ADDR) && wrData[3:0] > 4'd5) |=> $stable(laneCode)); // R9

  AST_IDLE_LANES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (laneCode == 4'hF) |=> (physAData == 16'h0 && !physAValid && physBData == 16'h0 && !physBValid)); // R9
endmodule

bind linkCfgBank linkCfgBankChk #(.ADDR_W(ADDR_W), .QCFG_ADDR(QCFG_ADDR), .LANE_ADDR(LANE_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
  .linkACfg(linkACfg), .linkBCfg(linkBCfg), .syncFromA(syncFromA), .laneCode(laneCode),
  .physAData(physAData), .physAValid(physAValid), .physBData(physBData), .physBValid(physBValid)
);

// File: tb/tb_linkCfgBank.sv
module tb_linkCfgBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [71:0] linkACfg, linkBCfg;
  logic syncFromA;
  logic [15:0] srcAData0 = '0, srcAData1 = '0, srcBData0 = '0, srcBData1 = '0;
  logic [3:0] srcValid = '0;
  logic [15:0] physAData, physBData;
  logic physAValid, physBValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  linkCfgBank dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .linkACfg(linkACfg), .linkBCfg(linkBCfg), .syncFromA(syncFromA),
    .srcAData0(srcAData0), .srcAData1(srcAData1), .srcBData0(srcBData0), .srcBData1(srcBData1),
    .srcValid(srcValid), .physAData(physAData), .physAValid(physAValid),
    .physBData(physBData), .physBValid(physBValid)
  );

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [71:0] cfgOf(input logic [7:0] m, k, f, l, ctl);
    return {ctl, 8'd0, l, f, 8'd1, k, 8'd0, 8'd16, m};
  endfunction

  task automatic wrReg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; addr = 6'h3F;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [7:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic setSrc();
    srcAData0 = 16'h1111; srcAData1 = 16'h2222; srcBData0 = 16'h3333; srcBData1 = 16'h4444;
    srcValid = 4'hF;
  endtask

  task automatic chkRoute(input string tag, input logic [15:0] expA, input logic [15:0] expB);
    @(negedge clk); @(negedge clk);
    chk({tag, " physA"}, 72'(physAData), 72'(expA));
    chk({tag, " physB"}, 72'(physBData), 72'(expB));
    chk({tag, " valids"}, 72'({physAValid, physBValid}), 72'(2'b11));
  endtask

  task automatic testReset();
    logic [7:0] d;
    rdReg(6'h01, d); chk("R9 reset lane reads F", 72'(d), 72'h0F);
    rdReg(6'h02, d); chk("R11 reset sync", 72'(d), 72'h00);
    chk("R11 reset linkA", linkACfg, 72'h0);
    setSrc();
    @(negedge clk); @(negedge clk);
    chk("R9 idle lanes data", 72'({physAData, physBData}), 72'h0);
    chk("R9 idle lanes valid", 72'({physAValid, physBValid}), 72'h0);
  endtask

  task automatic testPreset001();
    logic [7:0] d;
    wrReg(6'h00, 8'h01);
    chk("R2 linkA", linkACfg, cfgOf(1, 16, 2, 1, 0));
    chk("R2 linkB", linkBCfg, cfgOf(1, 16, 2, 1, 0));
    chk("R2 sync", 72'(syncFromA), 72'h0);
    rdReg(6'h01, d); chk("R2 lane code", 72'(d), 72'h00);
    rdReg(6'h13, d); chk("R6 readback K next cycle", 72'(d), 72'd16);
    rdReg(6'h00, d); chk("R1 quick reads zero", 72'(d), 72'h00);
  endtask

  task automatic testDirectLanes();
    chkRoute("R7 code0", 16'h1111, 16'h3333);
    wrReg(6'h01, 8'h01);
    chkRoute("R7 code1", 16'h3333, 16'h1111);
  endtask

  task automatic testPreset010();
    logic [7:0] d;
    wrReg(6'h00, 8'h02);
    chk("R3 linkA", linkACfg, cfgOf(2, 16, 2, 2, 8'h14));
    chk("R3 linkB", linkBCfg, cfgOf(2, 16, 2, 2, 8'h01));
    chk("R3 sync", 72'(syncFromA), 72'h1);
    rdReg(6'h01, d); chk("R3 lane code", 72'(d), 72'h02);
    chkRoute("R8 code2", 16'h1111, 16'h2222);
    wrReg(6'h01, 8'h03); chkRoute("R8 code3", 16'h2222, 16'h1111);
    wrReg(6'h01, 8'h04); chkRoute("R8 code4", 16'h3333, 16'h4444);
    wrReg(6'h01, 8'h05); chkRoute("R8 code5", 16'h4444, 16'h3333);
  endtask

  task automatic testReservedLane();
    logic [7:0] d;
    wrReg(6'h01, 8'h07);
    rdReg(6'h01, d); chk("R9 reserved lane ignored", 72'(d), 72'h05);
    chkRoute("R9 routing held", 16'h4444, 16'h3333);
  endtask

  task automatic testOverwriteAndReserved();
    logic [7:0] d;
    logic [71:0] a0, b0;
    wrReg(6'h10, 8'h33);
    rdReg(6'h10, d); chk("R6 overwrite after preset", 72'(d), 72'h33);
    a0 = linkACfg; b0 = linkBCfg;
    wrReg(6'h00, 8'h05);
    chk("R5 reserved quick linkA", linkACfg, a0);
    chk("R5 reserved quick linkB", linkBCfg, b0);
    rdReg(6'h01, d); chk("R5 reserved quick lane", 72'(d), 72'h05);
    wrReg(6'h00, 8'h00);
    chk("R1 code0 linkA unchanged", linkACfg, a0);
    chk("R1 code0 sync unchanged", 72'(syncFromA), 72'h1);
  endtask

  task automatic testPreset011();
    logic [7:0] d;
    wrReg(6'h00, 8'h03);
    chk("R4 linkA", linkACfg, cfgOf(2, 8, 4, 1, 8'h14));
    chk("R4 linkB", linkBCfg, cfgOf(2, 8, 4, 1, 8'h01));
    chk("R4 sync", 72'(syncFromA), 72'h1);
    rdReg(6'h01, d); chk("R4 lane code", 72'(d), 72'h00);
  endtask

  task automatic testLatencyValid();
    @(negedge clk); @(negedge clk);
    srcValid = 4'b1110; srcAData0 = 16'hAAAA;
    #1; chk("R10 no change before edge", 72'(physAData), 72'h1111);
    @(negedge clk);
    chk("R10 data after one edge", 72'(physAData), 72'hAAAA);
    chk("R10 valid follows source", 72'({physAValid, physBValid}), 72'(2'b01));
  endtask

  task automatic testMap();
    logic [7:0] d;
    wrReg(6'h3F, 8'hFF);
    rdReg(6'h3F, d); chk("R11 unmapped reads zero", 72'(d), 72'h00);
    wrReg(6'h02, 8'h00);
    rdReg(6'h02, d); chk("R11 sync reg", 72'(d), 72'h00);
    chk("R11 sync output", 72'(syncFromA), 72'h0);
    rdReg(6'h28, d); chk("R11 linkB ctl addr", 72'(d), 72'h01);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPreset001();
    testDirectLanes();
    testPreset010();
    testReservedLane();
    testOverwriteAndReserved();
    testPreset011();
    testLatencyValid();
    testMap();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule